// File: doc/BRIEF.md
# Video and Sliced-VBI Output Arbiter

This block shares a single byte-wide output stream between scaled video lines and packets of sliced vertical-blanking data. Video arrives as whole lines, each already carrying its own start and end timing codes, with the final byte of the line marked. Sliced data arrives as a packet, held valid by an upstream buffer until it has been taken, with its final byte marked. A five-bit mode word, a region-overlap input and the presence of a waiting packet decide what happens on each line.

When the scaler window overlaps the configured VBI line region, a waiting packet is either appended right after the end code of the current line, which places it in horizontal blanking, or it replaces that line outright. In the replace case the whole video line, timing codes included, is consumed and discarded. The packet goes out behind a four-byte ancillary-data preamble or between a pair of start/end code groups, and byte values that collide with timing-code patterns can optionally be rewritten. All three streams use valid/ready. A source must keep valid high and its data stable until ready is seen. The block keeps out_valid and out_data stable while out_ready is low, and stalls its sources for as long as the output is stalled.

Top module: `vbi_video_arbiter`

## Requirements
- R1: vid_ready and vbi_ready are never high in the same cycle, so only one source owns the output at any time.
- R2: With cfg_mode[4]=0, a nonzero format field cfg_mode[3:0], region_hit=1 and a packet waiting, every byte of the video line is output unchanged. The framed packet follows immediately after the last byte of that line.
- R3: With cfg_mode[4]=1, a nonzero format, region_hit=1 and a packet waiting when the line starts, no byte of that line appears on the output. Its timing codes are dropped too. The framed packet is output in its place.
- R4: With region_hit=0 the video line passes unchanged and a waiting packet is neither consumed nor output.
- R5: A format field of 1 to 7 puts the preamble 00h, FFh, FFh, ANC_DID in front of the payload, and no trailer follows.
- R6: A format field with bit 3 set frames the payload as FFh, 00h, 00h, VBI_SAV_CODE, then the payload, then FFh, 00h, 00h, VBI_EAV_CODE.
- R7: A format field of 0 disables sliced output. Video passes unchanged whatever cfg_mode[4] and region_hit are, and a waiting packet stays untouched.
- R8: When format bit 0 is set, payload byte 00h is output as 03h and payload byte FFh as FCh.
- R9: When format bit 0 is clear, payload bytes 00h and FFh are output as received.
- R10: Once a packet's first framing byte has been offered, vid_ready stays low until its last byte has been accepted. A line that starts meanwhile is held.
- R11: out_is_vbi is high exactly on framing and payload bytes of a packet, and low on video bytes and after reset.
- R12: cfg_mode and region_hit are captured when a line starts. Changes during the line and its packet do not alter how that line is handled.
- R13: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 5 | [3:0] format field, [4] replace-line mode |
| region_hit | input | 1 | Scaler window overlaps the VBI line region |
| vid_valid | input | 1 | Video byte valid |
| vid_ready | output | 1 | Video byte accepted |
| vid_data | input | DATA_W | Video byte |
| vid_last | input | 1 | Last byte of the video line |
| vbi_valid | input | 1 | Sliced byte valid / packet waiting |
| vbi_ready | output | 1 | Sliced byte accepted |
| vbi_data | input | DATA_W | Sliced payload byte |
| vbi_last | input | 1 | Last payload byte of the packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | DATA_W | Output byte |
| out_is_vbi | output | 1 | Output byte belongs to a sliced packet |

## Verification
The bench builds the block with DATA_W of 8 and with the preamble identifier and the two code bytes overridden to 5Ah, ECh and F1h. These values differ from the defaults and from each other, so a header or trailer taken from the wrong slot shows up as a wrong byte. With 8-bit data, the payload values 00h and FFh can be injected on purpose, which puts both the rewrite and the pass-through cases within reach. Random back-pressure on out_ready exercises the stall paths of every state.

// File: rtl/vbi_arb_pkg.sv
`timescale 1ns/1ps
package vbi_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VIDEO = 3'd1,
    ST_DROP  = 3'd2,
    ST_HEAD  = 3'd3,
    ST_BODY  = 3'd4,
    ST_TAIL  = 3'd5
  } arb_state_e;

  // Preamble and trailer both hold three marker bytes and one code byte.
  localparam int FRAME_LEN = 4;
  localparam int FIDX_W    = $clog2(FRAME_LEN);
  localparam int FMT_W     = 4;
endpackage

// File: rtl/vbi_arb_ctrl.sv
`timescale 1ns/1ps
module vbi_arb_ctrl
  import vbi_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W:0]    cfg_mode,
  input  logic              region_hit,
  input  logic              vid_valid,
  input  logic              vid_last,
  input  logic              vbi_valid,
  input  logic              vbi_last,
  input  logic              out_ready,
  output logic              vid_ready,
  output logic              vbi_ready,
  output logic              out_valid,
  output logic              out_is_vbi,
  output arb_state_e        state_q,
  output logic [FIDX_W-1:0] idx_q,
  output logic [FMT_W-1:0]  lat_fmt
);
  localparam logic [FIDX_W-1:0] IDX_END = FIDX_W'(FRAME_LEN - 1);

  arb_state_e        state_d;
  logic [FIDX_W-1:0] idx_d;
  logic              lat_skip, lat_hit, grab;
  logic              fmt_on_now, fmt_on_lat;

  assign fmt_on_now = (cfg_mode[FMT_W-1:0] != '0);
  assign fmt_on_lat = (lat_fmt != '0);

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    vid_ready  = 1'b0;
    vbi_ready  = 1'b0;
    out_valid  = 1'b0;
    out_is_vbi = 1'b0;
    grab       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (vid_valid) begin
          grab    = 1'b1;
          state_d = (fmt_on_now && region_hit && cfg_mode[FMT_W] && vbi_valid)
                    ? ST_DROP : ST_VIDEO;
        end
      end
      ST_VIDEO: begin
        out_valid = vid_valid;
        vid_ready = out_ready;
        if (vid_valid && out_ready && vid_last)
          state_d = (fmt_on_lat && lat_hit && !lat_skip && vbi_valid)
                    ? ST_HEAD : ST_IDLE;
      end
      ST_DROP: begin
        vid_ready = 1'b1;
        if (vid_valid && vid_last) state_d = ST_HEAD;
      end
      ST_HEAD, ST_TAIL: begin
        out_valid  = 1'b1;
        out_is_vbi = 1'b1;
        if (out_ready) begin
          if (idx_q == IDX_END) begin
            idx_d   = '0;
            state_d = (state_q == ST_HEAD) ? ST_BODY : ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_BODY: begin
        out_is_vbi = 1'b1;
        out_valid  = vbi_valid;
        vbi_ready  = out_ready;
        if (vbi_valid && out_ready && vbi_last)
          state_d = lat_fmt[FMT_W-1] ? ST_TAIL : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      lat_fmt  <= '0;
      lat_skip <= 1'b0;
      lat_hit  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (grab) begin
        lat_fmt  <= cfg_mode[FMT_W-1:0];
        lat_skip <= cfg_mode[FMT_W];
        lat_hit  <= region_hit;
      end
    end
  end
endmodule

// File: rtl/vbi_arb_frame.sv
`timescale 1ns/1ps
module vbi_arb_frame
  import vbi_arb_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] ANC_DID      = 'h91,
  parameter logic [DATA_W-1:0] VBI_SAV_CODE = 'hAB,
  parameter logic [DATA_W-1:0] VBI_EAV_CODE = 'hB6
) (
  input  arb_state_e        state,
  input  logic [FIDX_W-1:0] idx,
  input  logic              use_codes,
  input  logic              recode,
  input  logic [DATA_W-1:0] vid_data,
  input  logic [DATA_W-1:0] vbi_data,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [DATA_W-1:0] RC_LO = DATA_W'(3);
  localparam logic [DATA_W-1:0] RC_HI = ~RC_LO;
  localparam logic [FIDX_W-1:0] IDX_END = FIDX_W'(FRAME_LEN - 1);

  logic [DATA_W-1:0] head_byte, tail_byte, body_byte;

  // Marker bytes: preamble is 0,1,1 for ancillary framing and 1,0,0 for code framing.
  always_comb begin
    if (idx == IDX_END)      head_byte = use_codes ? VBI_SAV_CODE : ANC_DID;
    else if (idx == '0)      head_byte = use_codes ? '1 : '0;
    else                     head_byte = use_codes ? '0 : '1;
    if (idx == IDX_END)      tail_byte = VBI_EAV_CODE;
    else if (idx == '0)      tail_byte = '1;
    else                     tail_byte = '0;
  end

  always_comb begin
    body_byte = vbi_data;
    if (recode) begin
      if (vbi_data == '0)      body_byte = RC_LO;
      else if (vbi_data == '1) body_byte = RC_HI;
    end
  end

  always_comb begin
    unique case (state)
      ST_VIDEO: out_data = vid_data;
      ST_HEAD:  out_data = head_byte;
      ST_BODY:  out_data = body_byte;
      ST_TAIL:  out_data = tail_byte;
      default:  out_data = '0;
    endcase
  end
endmodule

// File: rtl/vbi_video_arbiter.sv
`timescale 1ns/1ps
module vbi_video_arbiter
  import vbi_arb_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] ANC_DID      = 'h91,
  parameter logic [DATA_W-1:0] VBI_SAV_CODE = 'hAB,
  parameter logic [DATA_W-1:0] VBI_EAV_CODE = 'hB6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cfg_mode,
  input  logic              region_hit,
  input  logic              vid_valid,
  output logic              vid_ready,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              vid_last,
  input  logic              vbi_valid,
  output logic              vbi_ready,
  input  logic [DATA_W-1:0] vbi_data,
  input  logic              vbi_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_vbi
);
  arb_state_e        state_q;
  logic [FIDX_W-1:0] idx_q;
  logic [FMT_W-1:0]  lat_fmt;

  vbi_arb_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .region_hit (region_hit),
    .vid_valid  (vid_valid),
    .vid_last   (vid_last),
    .vbi_valid  (vbi_valid),
    .vbi_last   (vbi_last),
    .out_ready  (out_ready),
    .vid_ready  (vid_ready),
    .vbi_ready  (vbi_ready),
    .out_valid  (out_valid),
    .out_is_vbi (out_is_vbi),
    .state_q    (state_q),
    .idx_q      (idx_q),
    .lat_fmt    (lat_fmt)
  );

  vbi_arb_frame #(
    .DATA_W       (DATA_W),
    .ANC_DID      (ANC_DID),
    .VBI_SAV_CODE (VBI_SAV_CODE),
    .VBI_EAV_CODE (VBI_EAV_CODE)
  ) frame_i (
    .state     (state_q),
    .idx       (idx_q),
    .use_codes (lat_fmt[FMT_W-1]),
    .recode    (lat_fmt[0]),
    .vid_data  (vid_data),
    .vbi_data  (vbi_data),
    .out_data  (out_data)
  );
endmodule

// File: rtl/vbi_video_arbiter_chk.sv
`timescale 1ns/1ps
module vbi_video_arbiter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vid_ready,
  input logic              vbi_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_is_vbi,
  input logic [3:0]        lat_fmt
);
  assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_ready && vbi_ready));

  assert_hold_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_video_in_packet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_vbi |-> !vid_ready);

  assert_disabled_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_fmt == 4'd0) |-> !out_is_vbi);

  assert_recode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_is_vbi && vbi_ready && out_valid && lat_fmt[0])
      |-> (out_data != '0 && out_data != '1));

  assert_payload_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vbi_ready |-> out_is_vbi);
endmodule

bind vbi_video_arbiter vbi_video_arbiter_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/vbi_video_arbiter_tb.sv
`timescale 1ns/1ps
module vbi_video_arbiter_tb_top;
  localparam int         DW   = 8;
  localparam logic [7:0] DID  = 8'h5A;
  localparam logic [7:0] SAVC = 8'hEC;
  localparam logic [7:0] EAVC = 8'hF1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    cfg_mode = '0;
  logic          region_hit = 1'b0;
  logic          vid_valid = 1'b0, vid_last = 1'b0, vid_ready;
  logic [DW-1:0] vid_data = '0;
  logic          vbi_valid = 1'b0, vbi_last = 1'b0, vbi_ready;
  logic [DW-1:0] vbi_data = '0;
  logic          out_valid, out_is_vbi;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  vbi_video_arbiter #(
    .DATA_W(DW), .ANC_DID(DID), .VBI_SAV_CODE(SAVC), .VBI_EAV_CODE(EAVC)
  ) dut_i (.*);

  logic [DW:0]   vid_q[$], vbi_q[$], exp_q[$];
  logic [DW-1:0] pend[$];
  int    checks = 0, fails = 0;
  string cur_req = "R11";
  bit    bp = 1'b0;
  bit    vid_fire, vbi_fire, stall_prev;
  logic [DW-1:0] prev_data;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] recode_b(input logic [DW-1:0] b, input bit on);
    if (on && b == 8'h00) return 8'h03;
    if (on && b == 8'hFF) return 8'hFC;
    return b;
  endfunction

  // Cycle engine: sample at negedge, drive just after posedge.
  initial begin
    forever begin
      @(negedge clk);
      vid_fire = vid_valid && vid_ready;
      vbi_fire = vbi_valid && vbi_ready;
      if (rst_n) begin
        check(!(vid_ready && vbi_ready), "R1", "dual grant", 16'(vbi_ready), 16'h0);
        if (out_is_vbi) check(!vid_ready, "R10", "video granted in packet", 16'(vid_ready), 16'h0);
        if (stall_prev)
          check(out_valid && out_data == prev_data, "R13", "stall hold",
                {7'h0, out_valid, out_data}, {8'h01, prev_data});
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0)
            check(1'b0, cur_req, "unexpected byte", {7'h0, out_is_vbi, out_data}, 16'hFFFF);
          else begin
            logic [DW:0] e;
            e = exp_q.pop_front();
            check({out_is_vbi, out_data} == e, cur_req, "output byte",
                  {7'h0, out_is_vbi, out_data}, {7'h0, e});
          end
        end
        stall_prev = out_valid && !out_ready;
        prev_data  = out_data;
      end
      @(posedge clk);
      #1;
      if (vid_fire) void'(vid_q.pop_front());
      if (vbi_fire) void'(vbi_q.pop_front());
      vid_valid = (vid_q.size() != 0);
      {vid_last, vid_data} = vid_valid ? vid_q[0] : '0;
      vbi_valid = (vbi_q.size() != 0);
      {vbi_last, vbi_data} = vbi_valid ? vbi_q[0] : '0;
      out_ready = bp ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic add_packet(input int plen, input bit force_codes);
    for (int i = 0; i < plen; i++) begin
      logic [DW-1:0] b;
      int r;
      r = $urandom % 8;
      b = (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : DW'($urandom);
      if (force_codes && i == 0) b = 8'h00;
      if (force_codes && i == 1) b = 8'hFF;
      pend.push_back(b);
      vbi_q.push_back({(i == plen - 1), b});
    end
  endtask

  task automatic run_trial(input logic [3:0] fmt, input bit skip, input bit hit,
                           input int vlen, input int plen, input bit force_codes,
                           input bit flip, input string req);
    bit ins;
    cur_req = req;
    if (plen > 0 && pend.size() == 0) add_packet(plen, force_codes);
    cfg_mode   = {skip, fmt};
    region_hit = hit;
    wait_cyc(3);
    ins = (fmt != 0) && hit && (pend.size() != 0);
    for (int i = 0; i < vlen; i++) begin
      logic [DW-1:0] b;
      b = DW'($urandom);
      vid_q.push_back({(i == vlen - 1), b});
      if (!(ins && skip)) exp_q.push_back({1'b0, b});
    end
    if (ins) begin
      if (fmt[3]) begin
        exp_q.push_back({1'b1, 8'hFF}); exp_q.push_back({1'b1, 8'h00});
        exp_q.push_back({1'b1, 8'h00}); exp_q.push_back({1'b1, SAVC});
      end else begin
        exp_q.push_back({1'b1, 8'h00}); exp_q.push_back({1'b1, 8'hFF});
        exp_q.push_back({1'b1, 8'hFF}); exp_q.push_back({1'b1, DID});
      end
      foreach (pend[i]) exp_q.push_back({1'b1, recode_b(pend[i], fmt[0])});
      if (fmt[3]) begin
        exp_q.push_back({1'b1, 8'hFF}); exp_q.push_back({1'b1, 8'h00});
        exp_q.push_back({1'b1, 8'h00}); exp_q.push_back({1'b1, EAVC});
      end
      pend.delete();
    end
    if (flip) begin
      wait_cyc(4);
      cfg_mode   = ~cfg_mode;
      region_hit = ~region_hit;
    end
    for (int n = 0; n < 3000 && (exp_q.size() != 0 || vid_q.size() != 0); n++)
      wait_cyc(1);
    wait_cyc(3);
    check(exp_q.size() == 0 && vid_q.size() == 0, req, "line/packet drained",
          16'(exp_q.size() + vid_q.size()), 16'h0);
    check(vbi_q.size() == pend.size(), req, "packet kept/consumed",
          16'(vbi_q.size()), 16'(pend.size()));
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !vid_ready && !vbi_ready && !out_is_vbi, "R11", "reset state",
          {12'h0, out_valid, vid_ready, vbi_ready, out_is_vbi}, 16'h0);
    wait_cyc(1);
    // Directed corner cases
    run_trial(4'd2, 1'b0, 1'b1, 10, 6, 1'b1, 1'b0, "R9");  // after line, ANC, no rewrite (R2 R5)
    run_trial(4'd1, 1'b0, 1'b1,  8, 5, 1'b1, 1'b0, "R8");  // rewrite of 00/FF
    run_trial(4'd8, 1'b0, 1'b1,  6, 4, 1'b0, 1'b0, "R6");  // code framing after line
    run_trial(4'd9, 1'b1, 1'b1, 12, 5, 1'b1, 1'b0, "R3");  // replace line, code framing
    run_trial(4'd3, 1'b1, 1'b1,  7, 3, 1'b0, 1'b0, "R5");  // replace line, ANC framing
    run_trial(4'd2, 1'b0, 1'b0,  9, 4, 1'b0, 1'b0, "R4");  // no overlap: packet kept
    run_trial(4'd0, 1'b1, 1'b1,  9, 4, 1'b0, 1'b0, "R7");  // disabled: packet kept
    run_trial(4'd2, 1'b0, 1'b1,  5, 4, 1'b0, 1'b0, "R2");  // kept packet now drains
    run_trial(4'd2, 1'b0, 1'b1, 20, 4, 1'b0, 1'b1, "R12"); // config flipped mid-line
    run_trial(4'd0, 1'b0, 1'b0, 20, 3, 1'b0, 1'b1, "R12"); // flip would enable: still none
    run_trial(4'd9, 1'b0, 1'b1,  3, 0, 1'b0, 1'b0, "R2");
    bp = 1'b1;
    run_trial(4'd11, 1'b1, 1'b1, 6, 7, 1'b1, 1'b0, "R13");
    // Constrained random
    for (int t = 0; t < 80; t++) begin
      logic [3:0] f;
      bit s, h, ins;
      int pl;
      string rq;
      f  = 4'($urandom);
      s  = 1'($urandom);
      h  = ($urandom % 4) != 0;
      pl = (($urandom % 10) < 7) ? 1 + int'($urandom % 12) : 0;
      ins = (f != 0) && h && (pend.size() != 0 || pl > 0);
      rq = (f == 0) ? "R7" : !h ? "R4" : !ins ? "R2" : s ? "R3" : "R2";
      run_trial(f, s, h, 1 + int'($urandom % 24), pl, 1'b0, 1'b0, rq);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule